// File: doc/BRIEF.md
# Armed Streaming Buffer with Divided Read Pacing

This block is a sixteen-entry buffer that sits between a memory fetch engine and a streaming consumer. The fetch engine writes words in at whatever rate it can. The consumer receives one word every N system clocks, where N is programmable from 1 to 16. Storage is a plain two-port memory with one write port and one read port, so it maps onto block RAM.

The write side owns a full-width address pointer. Software can load this pointer, and it moves forward by one on each accepted write. Its current value is presented to the fetch engine as the next memory address. The read side keeps a 5-bit tag: four bits select the entry, and the top bit separates the full state from the empty state.

Streaming does not begin when data arrives. A trigger arms the output path with a delay count, and the first word leaves on a cycle fixed by that count. When the divide ratio is 1 and the buffer is empty, a word written on the same edge as a read step goes straight to the output.

Top module: `armed_stream_fifo`

## Requirements
- R1: After a synchronous reset the block reports the following: `empty`=1, `full`=0, `dout`=0, `dout_valid`=0, `streaming`=0, `overflow`=0, `underrun`=0, `mem_addr`=0.
- R2: Loading the pointer (`wr_load`=1) has three effects: it sets `mem_addr` to `wr_load_addr`, it sets the read tag to the low 5 bits of that value, and so it leaves the buffer empty. While `wr_load` is high, writes and read steps are ignored. Each accepted write raises `mem_addr` by one.
- R3: The buffer is empty when the 5-bit read tag equals the low 5 bits of `mem_addr`. It is full when the low 4 bits match and bit 4 differs. Sixteen writes with no reads make it full, and `full` and `empty` are never high together.
- R4: A write while full is dropped. `mem_addr` and the stored words stay unchanged, and `overflow` pulses high for one cycle after that edge.
- R5: Suppose the edge that samples `arm`=1 carries `arm_delay`=D. Then the first read step takes place in the cycle after D further edges, and its word shows on `dout` with `dout_valid`=1 after edge D+1 counted from the sampling edge.
- R6: Read steps after the first follow every N cycles, where N is `rate_n`. A value of 0 acts as 1, and values above 16 act as 16.
- R7: Words leave in the order they were written.
- R8: A read step on an empty buffer that is not a pass-through (see R9) does three things: `dout` keeps its last value, `dout_valid` stays low, and `underrun` pulses high. A write in that same cycle is stored for a later step.
- R9: When N is 1 and a read step meets an empty buffer together with an accepted write, the written word appears on `dout` with `dout_valid`=1 after that edge. `underrun` stays low, `mem_addr` still advances, and the buffer stays empty.
- R10: A new `arm` while streaming restarts the delay and the divider. The next step then follows the new trigger by the R5 rule, not the old phase.
- R11: `streaming` is high from the edge after `arm` until an edge that samples `stream_stop`=1 without `arm`. While it is low, no read steps occur and `dout_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_load | input | 1 | Load the write pointer and clear the buffer |
| wr_load_addr | input | ADDR_W (20) | Value loaded into the write pointer |
| wr_en | input | 1 | Write request from the fetch engine |
| wr_data | input | DATA_W (16) | Word to store |
| arm | input | 1 | Trigger that arms streaming |
| arm_delay | input | DLY_W (8) | Cycles between the trigger and the first read step |
| stream_stop | input | 1 | Ends streaming |
| rate_n | input | DIV_W (5) | Divide ratio N for read pacing |
| mem_addr | output | ADDR_W (20) | Current write pointer, given to the fetch engine |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| streaming | output | 1 | Pacer is armed or running |
| dout | output | DATA_W (16) | Streamed word, held between steps |
| dout_valid | output | 1 | `dout` was updated by the last edge |
| overflow | output | 1 | One-cycle pulse: a write was dropped |
| underrun | output | 1 | One-cycle pulse: a read step found no data |

## Verification
The assertions assume that every input is synchronous to `clk` and stays defined once reset is released. They also assume that `wr_load` is used only to repoint the buffer, because it deliberately discards any words already held. The bench drives every input on the falling edge and holds it for a whole cycle. It pulses `arm`, `stream_stop` and `wr_load` for exactly one cycle each, and it stops the pacer between scenarios, so each scenario starts from an idle pacer and a known occupancy.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;

  // Pacer states: idle, counting down the arm delay, running at divide-by-N
  typedef enum logic [1:0] {
    PACE_IDLE = 2'd0,
    PACE_WAIT = 2'd1,
    PACE_RUN  = 2'd2
  } pace_state_e;

endpackage

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
// Two-port storage with a registered read port, written for block RAM inference.
module sfifo_store #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The output register has a synchronous reset, as block RAM output registers allow
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_wptr.sv
`timescale 1ns/1ps
// Full-width write pointer: loadable, advances on accepted writes only.
module sfifo_wptr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + ADDR_W'(1);
  end
endmodule

// File: rtl/sfifo_pacer.sv
`timescale 1ns/1ps
// Trigger-armed read pacer: a start delay, then one step every N clocks.
module sfifo_pacer
  import sfifo_pkg::*;
#(
  parameter int DIV_W   = 5,
  parameter int DLY_W   = 8,
  parameter int MAX_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [DLY_W-1:0] arm_delay,
  input  logic             stop,
  input  logic [DIV_W-1:0] rate,
  output logic             step,
  output logic             armed,
  output logic             div_one
);
  localparam logic [DIV_W-1:0] RATE_MAX = DIV_W'(MAX_DIV);
  localparam logic [DIV_W-1:0] RATE_MIN = DIV_W'(1);

  pace_state_e      state;
  logic [DLY_W-1:0] dly_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] rate_eff;

  // Clamp N into 1..MAX_DIV
  always_comb begin
    if (rate == '0)          rate_eff = RATE_MIN;
    else if (rate > RATE_MAX) rate_eff = RATE_MAX;
    else                     rate_eff = rate;
  end

  assign div_one = (rate_eff == RATE_MIN);
  assign armed   = (state != PACE_IDLE);
  assign step    = ((state == PACE_WAIT) && (dly_cnt == '0)) ||
                   ((state == PACE_RUN)  && (div_cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PACE_IDLE;
      dly_cnt <= '0;
      div_cnt <= '0;
    end else if (arm) begin
      state   <= PACE_WAIT;
      dly_cnt <= arm_delay;
      div_cnt <= '0;
    end else if (stop) begin
      state   <= PACE_IDLE;
    end else begin
      unique case (state)
        PACE_WAIT: begin
          if (dly_cnt == '0) begin
            state   <= PACE_RUN;
            div_cnt <= rate_eff - RATE_MIN;
          end else begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end
        end
        PACE_RUN: begin
          if (div_cnt == '0) div_cnt <= rate_eff - RATE_MIN;
          else               div_cnt <= div_cnt - DIV_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/armed_stream_fifo.sv
`timescale 1ns/1ps
// Sixteen-entry streaming buffer with trigger-armed, divide-by-N read pacing.
module armed_stream_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 4,
  parameter int DIV_W  = 5,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic [ADDR_W-1:0] wr_load_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              arm,
  input  logic [DLY_W-1:0]  arm_delay,
  input  logic              stream_stop,
  input  logic [DIV_W-1:0]  rate_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              full,
  output logic              empty,
  output logic              streaming,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              overflow,
  output logic              underrun
);
  localparam int TAG_W   = IDX_W + 1;
  localparam int MAX_DIV = 1 << IDX_W;

  logic [ADDR_W-1:0] wptr;
  logic [TAG_W-1:0]  wr_tag;
  logic [TAG_W-1:0]  rd_tag;
  logic              step, div_one;
  logic              is_empty, is_full;
  logic              wr_ok, pop, pass, starve;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] pass_q;
  logic              pass_sel;

  assign wr_tag   = wptr[TAG_W-1:0];
  assign is_empty = (wr_tag == rd_tag);
  assign is_full  = (wr_tag[IDX_W-1:0] == rd_tag[IDX_W-1:0]) &&
                    (wr_tag[IDX_W] != rd_tag[IDX_W]);

  // Qualified events; a pointer load takes priority over everything else
  assign wr_ok  = wr_en && !wr_load && !is_full;
  assign pop    = step && !wr_load && !is_empty;
  assign pass   = step && !wr_load && is_empty && wr_ok && div_one;
  assign starve = step && !wr_load && is_empty && !pass;

  sfifo_wptr #(.ADDR_W(ADDR_W)) wptr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_load),
    .load_val (wr_load_addr),
    .inc      (wr_ok),
    .ptr      (wptr)
  );

  sfifo_pacer #(.DIV_W(DIV_W), .DLY_W(DLY_W), .MAX_DIV(MAX_DIV)) pacer_i (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .arm_delay (arm_delay),
    .stop      (stream_stop),
    .rate      (rate_n),
    .step      (step),
    .armed     (streaming),
    .div_one   (div_one)
  );

  sfifo_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_ok),
    .waddr (wptr[IDX_W-1:0]),
    .wdata (wr_data),
    .re    (pop),
    .raddr (rd_tag[IDX_W-1:0]),
    .rdata (mem_q)
  );

  // Read tag: realigned on load, advanced by a pop or a pass-through
  always_ff @(posedge clk) begin
    if (rst)              rd_tag <= '0;
    else if (wr_load)     rd_tag <= wr_load_addr[TAG_W-1:0];
    else if (pop || pass) rd_tag <= rd_tag + TAG_W'(1);
  end

  // Pass-through register and output select
  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q   <= '0;
      pass_sel <= 1'b0;
    end else begin
      if (pass)        pass_q   <= wr_data;
      if (pop || pass) pass_sel <= pass;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      overflow   <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      dout_valid <= pop || pass;
      overflow   <= wr_en && !wr_load && is_full;
      underrun   <= starve;
    end
  end

  assign dout     = pass_sel ? pass_q : mem_q;
  assign mem_addr = wptr;
  assign full     = is_full;
  assign empty    = is_empty;
endmodule

// File: rtl/sfifo_checker.sv
`timescale 1ns/1ps
module sfifo_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_load,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              full,
  input logic              empty,
  input logic              streaming,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input logic              overflow,
  input logic              underrun
);
  // R3
  a_r3_full_excludes_empty: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R2
  a_r2_addr_advances: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_load && !full) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R4
  a_r4_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_load && full) |=> (overflow && mem_addr == $past(mem_addr)));

  // R8
  a_r8_underrun_holds: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (!dout_valid && $stable(dout)));

  // R9
  a_r9_pass_from_empty: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && $past(empty)) |-> ($past(wr_en) && dout == $past(wr_data)));

  // R11
  a_r11_idle_no_output: assert property (@(posedge clk) disable iff (rst)
    !streaming |=> !dout_valid);
endmodule

bind armed_stream_fifo sfifo_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_load    (wr_load),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .mem_addr   (mem_addr),
  .full       (full),
  .empty      (empty),
  .streaming  (streaming),
  .dout       (dout),
  .dout_valid (dout_valid),
  .overflow   (overflow),
  .underrun   (underrun)
);

// File: tb/armed_stream_fifo_tb_top.sv
`timescale 1ns/1ps
module armed_stream_fifo_tb_top;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 20;
  localparam int DIV_W  = 5;
  localparam int DLY_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_load = 1'b0;
  logic [ADDR_W-1:0] wr_load_addr = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              arm = 1'b0;
  logic [DLY_W-1:0]  arm_delay = '0;
  logic              stream_stop = 1'b0;
  logic [DIV_W-1:0]  rate_n = 5'd1;
  logic [ADDR_W-1:0] mem_addr;
  logic              full, empty, streaming, dout_valid, overflow, underrun;
  logic [DATA_W-1:0] dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  armed_stream_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(4),
                      .DIV_W(DIV_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst(rst), .wr_load(wr_load), .wr_load_addr(wr_load_addr),
    .wr_en(wr_en), .wr_data(wr_data), .arm(arm), .arm_delay(arm_delay),
    .stream_stop(stream_stop), .rate_n(rate_n), .mem_addr(mem_addr),
    .full(full), .empty(empty), .streaming(streaming), .dout(dout),
    .dout_valid(dout_valid), .overflow(overflow), .underrun(underrun)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [DATA_W-1:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic arm_now(input logic [DIV_W-1:0] n, input logic [DLY_W-1:0] d);
    arm = 1'b1; rate_n = n; arm_delay = d;
    tick();
    arm = 1'b0;
  endtask

  task automatic stop_now();
    stream_stop = 1'b1;
    tick();
    stream_stop = 1'b0;
    tick();
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "dout", dout, 0);
    chk("R1", "dout_valid", dout_valid, 0);
    chk("R1", "streaming", streaming, 0);
    chk("R1", "mem_addr", mem_addr, 0);
    chk("R1", "flags", {overflow, underrun}, 0);
  endtask

  // R5 R6 R7 R8: delay 2, N=3, three words then a starved step
  task automatic t_basic();
    push(16'hA0); push(16'hA1); push(16'hA2);
    arm_now(5'd3, 8'd2);
    chk("R11", "streaming after arm", streaming, 1);
    for (int c = 2; c <= 14; c++) begin
      tick();
      if (c == 4 || c == 7 || c == 10) begin
        chk("R5_R6", $sformatf("valid c%0d", c), dout_valid, 1);
        chk("R7", $sformatf("order c%0d", c), dout, 16'hA0 + (c - 4) / 3);
      end else begin
        chk("R6", $sformatf("idle c%0d", c), dout_valid, 0);
      end
      chk("R8", $sformatf("underrun c%0d", c), underrun, (c == 13) ? 1 : 0);
      if (c >= 11) chk("R8", $sformatf("hold c%0d", c), dout, 16'hA2);
    end
    stop_now();
    chk("R11", "streaming after stop", streaming, 0);
  endtask

  // R10: re-arm restarts divider phase
  task automatic t_rearm();
    push(16'hB0); push(16'hB1);
    arm_now(5'd4, 8'd0);
    tick();
    chk("R10", "first word", dout, 16'hB0);
    tick();
    chk("R10", "gap", dout_valid, 0);
    arm = 1'b1; arm_delay = 8'd0;
    tick();
    arm = 1'b0;
    chk("R10", "no step yet", dout_valid, 0);
    tick();
    chk("R10", "restarted valid", dout_valid, 1);
    chk("R10", "restarted data", dout, 16'hB1);
    tick();
    chk("R10", "old phase gone", dout_valid, 0);
    stop_now();
  endtask

  // R9: pass-through at N=1
  task automatic t_pass();
    logic [ADDR_W-1:0] base;
    base = mem_addr;
    arm_now(5'd1, 8'd0);
    wr_en = 1'b1; wr_data = 16'h501;
    for (int c = 2; c <= 6; c++) begin
      tick();
      chk("R9", $sformatf("valid c%0d", c), dout_valid, 1);
      chk("R9", $sformatf("data c%0d", c), dout, 16'h500 + c - 1);
      chk("R9", $sformatf("empty c%0d", c), empty, 1);
      chk("R9", $sformatf("no underrun c%0d", c), underrun, 0);
      wr_data = 16'(16'h500 + c);
    end
    wr_en = 1'b0;
    tick();
    chk("R9", "addr advanced", mem_addr, base + 20'd5);
    chk("R8", "starved after pass", underrun, 1);
    chk("R8", "held pass word", dout, 16'h505);
    stop_now();
  endtask

  // R8: N=2, write meeting a step on empty is stored, not passed
  task automatic t_no_pass();
    arm_now(5'd2, 8'd0);
    wr_en = 1'b1; wr_data = 16'h601;
    tick();
    wr_en = 1'b0;
    chk("R8", "underrun at N2", underrun, 1);
    chk("R8", "no valid at N2", dout_valid, 0);
    chk("R8", "word stored", empty, 0);
    tick();
    chk("R8", "between steps", dout_valid, 0);
    tick();
    chk("R8", "stored word out", dout_valid, 1);
    chk("R8", "stored data", dout, 16'h601);
    stop_now();
  endtask

  // R6: rate above 16 clamps to 16
  task automatic t_clamp();
    push(16'hC0); push(16'hC1);
    arm_now(5'd31, 8'd0);
    for (int c = 2; c <= 19; c++) begin
      tick();
      chk("R6", $sformatf("clamp c%0d", c), dout_valid, (c == 2 || c == 18) ? 1 : 0);
      if (c == 2)  chk("R7", "clamp w0", dout, 16'hC0);
      if (c == 18) chk("R7", "clamp w1", dout, 16'hC1);
    end
    stop_now();
  endtask

  // R11: stopped pacer does not read
  task automatic t_stopped();
    int seen = 0;
    push(16'hD0);
    for (int c = 0; c < 20; c++) begin
      tick();
      if (dout_valid) seen++;
    end
    chk("R11", "no output while stopped", seen, 0);
    chk("R11", "word kept", empty, 0);
  endtask

  // R2 R3 R4 R7 R6: preload, fill, overflow, drain at rate 0
  task automatic t_overflow();
    wr_load = 1'b1; wr_load_addr = 20'h12345;
    tick();
    wr_load = 1'b0;
    chk("R2", "preload addr", mem_addr, 20'h12345);
    chk("R2", "preload empties", empty, 1);
    for (int i = 0; i < 16; i++) push(16'(16'h100 + i));
    chk("R3", "full after 16", full, 1);
    chk("R3", "not empty when full", empty, 0);
    chk("R2", "addr after 16", mem_addr, 20'h12355);
    push(16'hDEAD);
    chk("R4", "overflow pulse", overflow, 1);
    chk("R4", "addr unchanged", mem_addr, 20'h12355);
    tick();
    chk("R4", "overflow clears", overflow, 0);
    arm_now(5'd0, 8'd0);
    for (int c = 2; c <= 17; c++) begin
      tick();
      chk("R6", $sformatf("rate0 valid c%0d", c), dout_valid, 1);
      chk("R4", $sformatf("drain c%0d", c), dout, 16'h100 + c - 2);
    end
    chk("R3", "empty after drain", empty, 1);
    stop_now();
  endtask

  initial begin
    #500000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    tick();
    t_reset();
    t_basic();
    t_rearm();
    t_pass();
    t_no_pass();
    t_clamp();
    t_stopped();
    t_overflow();
    report();
  end
endmodule